// File: doc/BRIEF.md
# Adaptive Echo and Crosstalk Canceller

This block removes self-interference from a received sample stream in a full-duplex twisted-pair transceiver. Alongside each received sample it takes the five-level symbol the local transmitter sent on the same clock. It keeps the recent symbols in a tapped delay line and weights them with adaptive coefficients to build an estimate of the interference. The estimate is subtracted from the received sample, and the cleaned difference is the block's output.

The same difference serves as the error for a least-mean-squares update of every coefficient. The step size is a power of two, so each coefficient moves by the product of the error and the symbol at its tap, shifted right arithmetically. The symbols only take values from -2 to +2. Every tap product is therefore a selection among zero, the coefficient, its double and their negatives, so no general multiplier is needed.

The tap count is a parameter. It is set to 120 for a long echo path and to 20 for a short crosstalk path from a neighbouring pair. A freeze input stops adaptation while cancellation continues. The block takes one symbol and one sample on every clock.

Top module: `lmsc_canceller`

## Requirements
- R1: The block takes one symbol and one received sample on every rising edge. The `err_out` value registered at edge n+1 equals the sample taken at edge n minus the sum of h_k·x(n-k) for k = 0 to NTAPS-1, with the error clamped as in R3. h_k is the coefficient held between edges n and n+1, and x(n-k) is the symbol taken k edges before edge n.
- R2: A symbol taken at edge n acts on tap k during the cycle that follows edge n+k. A symbol taken NTAPS or more edges earlier has no influence on the output.
- R3: The error is clamped to the signed 12-bit range [-2048, 2047] before it is registered onto `err_out`.
- R4: When adaptation is enabled at an edge, each coefficient h_k becomes h_k + ((e·x_k) >>> mu). Here e is the clamped error registered at that same edge, x_k is the symbol at tap k, and the shift is arithmetic, rounding toward minus infinity.
- R5: The shift amount mu is the unsigned value on `mu_shift` (0 to 15) sampled at the updating edge.
- R6: While `adapt_freeze` is high at an edge, no coefficient changes at that edge. The error is still computed and registered.
- R7: Each coefficient update clamps the result to the signed COEF_W-bit range instead of wrapping.
- R8: An active-low asynchronous `rst_n` clears all coefficients, the symbol delay line, the registered sample and `err_out` to zero.
- R9: `sym_in` is three-bit two's complement: 000 is 0, 001 is +1, 010 is +2, 111 is -1 and 110 is -2. The codes 011, 100 and 101 are treated as 0 in both the estimate and the update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Symbol clock, one sample and one symbol per rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_in | input | 3 | Transmitted five-level symbol, two's complement code |
| rx_in | input | RX_W (12) | Received sample, signed |
| mu_shift | input | MU_W (4) | Step-size exponent; update is shifted right by this amount |
| adapt_freeze | input | 1 | High holds all coefficients |
| err_out | output | RX_W (12) | Cancelled sample, which is also the adaptation error, signed |

## Verification
The hardest state to reach from the ports is coefficient clamping. A converging filter settles long before any coefficient nears full scale, so the clamp is never exercised by well-behaved stimulus. The bench builds a crosstalk-sized instance with narrow coefficients and runs a constant +2 symbol stream with a zero shift and a full-scale received sample. The first update then already exceeds the coefficient range, and the following oscillation also drives the error into its clamp at both extremes. Frozen impulse runs after adaptation expose the individual taps one per cycle, which shows where each delayed symbol lands.

// File: rtl/lmsc_pkg.sv
package lmsc_pkg;

    localparam int SYM_W = 3;

    typedef logic signed [SYM_W-1:0] sym_t;

    // Map the three-bit symbol code onto the five legal levels; unused codes act as zero.
    function automatic sym_t sym_clean(input logic [SYM_W-1:0] code);
        sym_t v;
        case (code)
            3'b000, 3'b001, 3'b010, 3'b110, 3'b111: v = sym_t'(code);
            default:                                v = '0;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/lmsc_delay_line.sv
module lmsc_delay_line
    import lmsc_pkg::*;
#(
    parameter int NTAPS = 120
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [SYM_W-1:0]       sym_in,
    output logic [NTAPS*SYM_W-1:0] line_o
);

    typedef struct packed {
        sym_t [NTAPS-1:0] line;
    } dl_state_t;

    dl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.line[0] = sym_clean(sym_in);
        for (int k = 1; k < NTAPS; k++) begin
            st_d.line[k] = st_q.line[k-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_o = st_q.line;

endmodule

// File: rtl/lmsc_tap.sv
module lmsc_tap
    import lmsc_pkg::*;
#(
    parameter int COEF_W = 16,
    parameter int ERR_W  = 12,
    parameter int MU_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  sym_t                     sym_i,
    input  logic signed [ERR_W-1:0]  err_i,
    input  logic [MU_W-1:0]          mu_i,
    input  logic                     freeze_i,
    output logic signed [COEF_W-1:0] coef_o,
    output logic signed [COEF_W+1:0] prod_o
);

    localparam int PROD_W = COEF_W + 2;
    localparam int UPD_W  = ERR_W + 2;
    localparam int SUM_W  = ((COEF_W > UPD_W) ? COEF_W : UPD_W) + 1;
    localparam logic signed [SUM_W-1:0] C_MAX = SUM_W'((2**(COEF_W-1)) - 1);
    localparam logic signed [SUM_W-1:0] C_MIN = SUM_W'(-(2**(COEF_W-1)));

    typedef struct packed {
        logic signed [COEF_W-1:0] coef;
    } tap_state_t;

    tap_state_t st_d, st_q;

    logic signed [PROD_W-1:0] h_ext;
    logic signed [UPD_W-1:0]  e_ext;
    logic signed [UPD_W-1:0]  ex;
    logic signed [UPD_W-1:0]  delta;
    logic signed [SUM_W-1:0]  sum;

    // Replica contribution: pick 0, +-h or +-2h by symbol level.
    always_comb begin
        h_ext = PROD_W'(st_q.coef);
        case (sym_i)
            3'b001:  prod_o = h_ext;
            3'b111:  prod_o = -h_ext;
            3'b010:  prod_o = h_ext <<< 1;
            3'b110:  prod_o = -(h_ext <<< 1);
            default: prod_o = '0;
        endcase
    end

    // Coefficient adaptation with clamped result.
    always_comb begin
        e_ext = UPD_W'(err_i);
        case (sym_i)
            3'b001:  ex = e_ext;
            3'b111:  ex = -e_ext;
            3'b010:  ex = e_ext <<< 1;
            3'b110:  ex = -(e_ext <<< 1);
            default: ex = '0;
        endcase
        delta = ex >>> mu_i;
        sum   = SUM_W'(st_q.coef) + SUM_W'(delta);
        st_d  = st_q;
        if (!freeze_i) begin
            if (sum > C_MAX)      st_d.coef = C_MAX[COEF_W-1:0];
            else if (sum < C_MIN) st_d.coef = C_MIN[COEF_W-1:0];
            else                  st_d.coef = sum[COEF_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coef_o = st_q.coef;

endmodule

// File: rtl/lmsc_canceller.sv
module lmsc_canceller
    import lmsc_pkg::*;
#(
    parameter int NTAPS  = 120,
    parameter int RX_W   = 12,
    parameter int COEF_W = 16,
    parameter int MU_W   = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [2:0]             sym_in,
    input  logic signed [RX_W-1:0] rx_in,
    input  logic [MU_W-1:0]        mu_shift,
    input  logic                   adapt_freeze,
    output logic signed [RX_W-1:0] err_out
);

    localparam int PROD_W = COEF_W + 2;
    localparam int ACC_W  = PROD_W + $clog2(NTAPS) + 1;
    localparam int DIFF_W = ACC_W + 1;
    localparam logic signed [DIFF_W-1:0] E_MAX = DIFF_W'((2**(RX_W-1)) - 1);
    localparam logic signed [DIFF_W-1:0] E_MIN = DIFF_W'(-(2**(RX_W-1)));

    typedef struct packed {
        logic signed [RX_W-1:0] rx;
        logic signed [RX_W-1:0] err;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [NTAPS*SYM_W-1:0]   line_flat;
    logic [NTAPS*COEF_W-1:0]  coef_flat;
    logic signed [PROD_W-1:0] prod [NTAPS];
    logic signed [ACC_W-1:0]  acc;
    logic signed [DIFF_W-1:0] diff;
    logic signed [RX_W-1:0]   err_now;

    lmsc_delay_line #(.NTAPS(NTAPS)) line_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .sym_in (sym_in),
        .line_o (line_flat)
    );

    for (genvar k = 0; k < NTAPS; k++) begin : g_tap
        lmsc_tap #(
            .COEF_W (COEF_W),
            .ERR_W  (RX_W),
            .MU_W   (MU_W)
        ) tap_i (
            .clk      (clk),
            .rst_n    (rst_n),
            .sym_i    (sym_t'(line_flat[k*SYM_W +: SYM_W])),
            .err_i    (err_now),
            .mu_i     (mu_shift),
            .freeze_i (adapt_freeze),
            .coef_o   (coef_flat[k*COEF_W +: COEF_W]),
            .prod_o   (prod[k])
        );
    end

    // Replica sum, subtraction from the held sample, clamp of the error.
    always_comb begin
        acc = '0;
        for (int k = 0; k < NTAPS; k++) begin
            acc = acc + ACC_W'(prod[k]);
        end
        diff = DIFF_W'(st_q.rx) - DIFF_W'(acc);
        if (diff > E_MAX)      err_now = E_MAX[RX_W-1:0];
        else if (diff < E_MIN) err_now = E_MIN[RX_W-1:0];
        else                   err_now = diff[RX_W-1:0];
        st_d     = st_q;
        st_d.rx  = rx_in;
        st_d.err = err_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign err_out = st_q.err;

endmodule

// File: rtl/lmsc_checker.sv
module lmsc_checker #(
    parameter int NTAPS  = 120,
    parameter int COEF_W = 16,
    parameter int RX_W   = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   adapt_freeze,
    input logic signed [RX_W-1:0] err_out,
    input logic [NTAPS*COEF_W-1:0] coef_flat,
    input logic [NTAPS*3-1:0]     line_flat
);

    // R8: held reset leaves coefficients and output at zero
    p_reset_clear_r8: assert property (@(posedge clk)
        (!rst_n && $past(!rst_n)) |-> (coef_flat == '0 && err_out == '0));

    // R6: a frozen edge leaves every coefficient unchanged
    p_freeze_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        adapt_freeze |=> $stable(coef_flat));

    // R4: a zero error moves no coefficient
    p_zero_err_still_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_out == '0) |-> $stable(coef_flat));

    if (NTAPS > 1) begin : g_shift
        // R2: each symbol advances one tap per clock
        p_line_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
            line_flat[5:3] == $past(line_flat[2:0]));
    end

endmodule

bind lmsc_canceller lmsc_checker #(
    .NTAPS  (NTAPS),
    .COEF_W (COEF_W),
    .RX_W   (RX_W)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .adapt_freeze (adapt_freeze),
    .err_out      (err_out),
    .coef_flat    (coef_flat),
    .line_flat    (line_flat)
);

// File: tb/lmsc_canceller_tb.sv
`timescale 1ns/1ps
module lmsc_canceller_tb_top;

    localparam int TAPS = 20;
    localparam int CW   = 12;
    localparam int RW   = 12;

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [2:0]           sym_in = '0;
    logic signed [RW-1:0] rx_in = '0;
    logic [3:0]           mu_shift = '0;
    logic                 adapt_freeze = 1'b1;
    logic signed [RW-1:0] err_out;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int mx [TAPS];
    int mh [TAPS];
    int mr;
    int merr;
    int hist [4];

    always #2 clk = ~clk;

    lmsc_canceller #(
        .NTAPS  (TAPS),
        .RX_W   (RW),
        .COEF_W (CW),
        .MU_W   (4)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .sym_in       (sym_in),
        .rx_in        (rx_in),
        .mu_shift     (mu_shift),
        .adapt_freeze (adapt_freeze),
        .err_out      (err_out)
    );

    function automatic int clamp(input int v, input int w);
        int hi = (1 <<< (w - 1)) - 1;
        int lo = -(1 <<< (w - 1));
        if (v > hi) return hi;
        if (v < lo) return lo;
        return v;
    endfunction

    // R9 symbol levels
    function automatic int level(input logic [2:0] c);
        case (c)
            3'b001:  return 1;
            3'b010:  return 2;
            3'b111:  return -1;
            3'b110:  return -2;
            default: return 0;
        endcase
    endfunction

    function automatic logic [2:0] code_of(input int v);
        return 3'(v);
    endfunction

    task automatic model_clear();
        for (int k = 0; k < TAPS; k++) begin
            mx[k] = 0;
            mh[k] = 0;
        end
        mr = 0;
        merr = 0;
    endtask

    task automatic model_edge(input logic [2:0] code, input int r, input int mu, input bit frz);
        int acc = 0;
        int e;
        for (int k = 0; k < TAPS; k++) acc += mh[k] * mx[k];
        e = clamp(mr - acc, RW);
        if (!frz) begin
            for (int k = 0; k < TAPS; k++) mh[k] = clamp(mh[k] + ((e * mx[k]) >>> mu), CW);
        end
        for (int k = TAPS - 1; k > 0; k--) mx[k] = mx[k-1];
        mx[0] = level(code);
        mr = r;
        merr = e;
    endtask

    task automatic check(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic step(input logic [2:0] code, input int r, input int mu, input bit frz, input string tag);
        sym_in = code;
        rx_in = RW'(r);
        mu_shift = 4'(mu);
        adapt_freeze = frz;
        @(posedge clk);
        model_edge(code, r, mu, frz);
        @(negedge clk);
        check(tag, int'(err_out), merr);
    endtask

    function automatic int rnd(input int lo, input int hi);
        return lo + int'($urandom_range(hi - lo, 0));
    endfunction

    initial begin
        void'($urandom(32'd4242));
        model_clear();
        for (int i = 0; i < 4; i++) hist[i] = 0;
        repeat (3) @(negedge clk);
        check("R8 reset output", int'(err_out), 0);
        rst_n = 1'b1;

        // R1: zero coefficients, frozen: output is the previous sample
        for (int i = 0; i < 12; i++) step(3'b000, rnd(-2048, 2047), 0, 1'b1, "R1");

        // R9: illegal codes act as zero, no adaptation follows from them
        for (int i = 0; i < 20; i++) step(3'(3 + (i % 3)), rnd(-1500, 1500), 1, 1'b0, "R9");
        for (int i = 0; i < 25; i++) step(code_of(rnd(-2, 2)), rnd(-1000, 1000), 0, 1'b1, "R9");

        // R4, R5: converge onto a short synthetic echo, with varied step sizes
        for (int i = 0; i < 500; i++) begin
            int s = rnd(-2, 2);
            int r;
            hist[3] = hist[2]; hist[2] = hist[1]; hist[1] = hist[0]; hist[0] = s;
            r = 300 * hist[0] - 150 * hist[1] + 60 * hist[3] + rnd(-3, 3);
            if (i < 300) step(code_of(s), r, 7, 1'b0, "R4");
            else         step(code_of(s), r, rnd(6, 15), 1'b0, "R5");
        end

        // R6: frozen coefficients, cancellation continues
        for (int i = 0; i < 80; i++) step(code_of(rnd(-2, 2)), rnd(-800, 800), 0, 1'b1, "R6");

        // R2: single impulse walks across the taps, then leaves the line
        step(3'b010, 0, 0, 1'b1, "R2");
        for (int i = 0; i < TAPS + 6; i++) step(3'b000, 0, 0, 1'b1, "R2");

        // R7, R3: deliberate divergence reaches both clamps
        for (int i = 0; i < 60; i++) step(3'b010, 2047, 0, 1'b0, "R7");
        for (int i = 0; i < 60; i++) step(3'b110, -2048, 0, 1'b0, "R3");
        for (int i = 0; i < 40; i++) step(code_of(rnd(-2, 2)), rnd(-2048, 2047), 0, 1'b0, "R3");

        // R8: reset mid-run clears coefficients and line
        rst_n = 1'b0;
        @(negedge clk);
        model_clear();
        check("R8 mid-run reset", int'(err_out), 0);
        rst_n = 1'b1;
        for (int i = 0; i < 30; i++) step(code_of(rnd(-2, 2)), rnd(-2048, 2047), 0, 1'b1, "R8");

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule